// File: doc/BRIEF.md
# Interrupt and reset entry sequencer

This block runs the entry sequences that move an 8-bit processor core onto a new program counter. There are three such sequences: power-on reset, the non-maskable interrupt (NMI) and the maskable interrupt request (IRQ). The core keeps its own program counter, status and stack pointer. It raises a start strobe at every instruction boundary and presents those three values. The sequencer then decides whether an interrupt is due. If one is, it pushes the return state onto the stack in page 1 and fetches a 16-bit vector from the top of the address space. It then hands the new program counter, status and stack pointer back with a one-cycle done pulse. When nothing is due, the done pulse echoes the presented values back one cycle after the strobe.

NMI and one-shot IRQ requests are pulses that are latched until the next accepted boundary. Level IRQ sources form a bitmask, and any set bit requests service. A halt pulse puts the core into a jammed state, which blocks every interrupt until reset. The memory side is a request channel with valid/ready handshaking. The sequencer raises `bus_valid` and holds address, direction and write data unchanged until `bus_ready` is seen high. For a read, `bus_rdata` is taken in the handshake cycle itself. A stalled request simply lengthens the sequence, one cycle per cycle of back-pressure.

Top module: `intr_entry_seq`

## Requirements
- R1: After reset is released the block spends one idle cycle and then reads address 0xFFFC (low byte) and 0xFFFD (high byte), making no writes. It then pulses `seq_done` with `seq_kind`=01, `next_pc` equal to the two bytes read, `next_status`=0x04 and `next_sp`=0x00.
- R2: With `bus_ready` held high, an interrupt entry takes 7 cycles in total. These are the cycle in which the strobe is sampled, three writes, two reads and the done cycle. `seq_done` is therefore high in the sixth cycle after the sampling edge.
- R3: An entry writes the program counter high byte, then its low byte, then the status. Each write goes to address 0x0100 + S, and S is decremented by one (modulo 256) after each write. `next_sp` is the presented stack pointer minus 3.
- R4: The status byte written to the stack is the presented status with bit 4 cleared and bit 5 set. `next_status` after an NMI or IRQ has bit 4 cleared.
- R5: NMI reads its vector from 0xFFFA/0xFFFB and IRQ reads its vector from 0xFFFE/0xFFFF, low byte first.
- R6: A pending NMI wins over any IRQ request (`seq_kind`=10). NMI entry leaves bit 2 of the status unchanged.
- R7: An IRQ (`seq_kind`=11) is taken only when bit 2 (interrupt disable) was clear in the status that stood at the previous boundary. That status is the one presented at the previous accepted strobe, or the one handed out by the last done pulse. The live bit has no say. IRQ entry sets bit 2.
- R8: NMI and one-shot IRQ pulses stay pending until the next accepted strobe, which clears both whether or not anything is serviced. A pulse arriving in the same cycle as that strobe stays pending. Level IRQ sources are not latched.
- R9: A halt pulse blocks all servicing until reset: accepted strobes then behave as in R10. Reset clears the halt.
- R10: An accepted strobe with no service due gives `seq_done` in the next cycle with `seq_kind`=00, and `next_pc`, `next_status` and `next_sp` equal to the presented values.
- R11: `bus_valid` is high only during pushes and vector reads. While `bus_valid` is high and `bus_ready` low, `bus_valid`, `bus_write`, `bus_addr` and `bus_wdata` stay unchanged.
- R12: `seq_busy` is high from the cycle after an accepted strobe (or from reset) through the done cycle. A strobe seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release starts the reset sequence |
| bnd_start | input | 1 | Instruction boundary strobe, accepted when not busy |
| cur_pc | input | 16 | Program counter presented at the boundary |
| cur_status | input | 8 | Status presented at the boundary (bit 2 disable, bit 4 break, bit 5 unused) |
| cur_sp | input | 8 | Stack pointer presented at the boundary |
| nmi_pulse | input | 1 | Non-maskable request pulse, latched |
| irq_level | input | IRQ_SRC | Level IRQ sources, any bit set requests service |
| irq_pulse | input | 1 | One-shot IRQ request pulse, latched |
| halt_set | input | 1 | Enters the jammed state until reset |
| bus_valid | output | 1 | Memory request valid |
| bus_ready | input | 1 | Memory request accepted |
| bus_write | output | 1 | 1 for a stack write, 0 for a vector read |
| bus_addr | output | 16 | Request address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, taken in the handshake cycle |
| seq_busy | output | 1 | Sequence in progress |
| seq_done | output | 1 | One-cycle pulse; next_* valid |
| seq_kind | output | 2 | 00 none, 01 reset, 10 NMI, 11 IRQ; valid with seq_done |
| next_pc | output | 16 | Program counter to resume at |
| next_status | output | 8 | Status to resume with |
| next_sp | output | 8 | Stack pointer to resume with |

## Verification
The assertions take for granted that `bus_rdata` is valid in the cycle a read is accepted. They also assume the core presents `cur_pc`, `cur_status` and `cur_sp` in the cycle of the strobe. The bench drives read data straight from the requested address and changes its vector contents only while the block is idle. It raises the strobe for one cycle once the previous done pulse has passed, except in the deliberate strobe during a busy sequence. Request and halt inputs are single-cycle pulses. `bus_ready` is held high in the timed cases and toggled pseudo-randomly in the back-pressure cases.

// File: rtl/isq_pkg.sv
package isq_pkg;

  typedef enum logic [1:0] {
    K_NONE  = 2'd0,
    K_RESET = 2'd1,
    K_NMI   = 2'd2,
    K_IRQ   = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_BOOT,
    PH_PSH_H,
    PH_PSH_L,
    PH_PSH_P,
    PH_VEC_L,
    PH_VEC_H,
    PH_FIN
  } phase_e;

  // status bit positions
  localparam int FLG_I = 2;
  localparam int FLG_B = 4;
  localparam int FLG_U = 5;

  // vector offsets below the top address
  localparam int OFS_NMI = 5;
  localparam int OFS_RST = 3;
  localparam int OFS_IRQ = 1;

endpackage

// File: rtl/isq_req_latch.sv
module isq_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic done,
  input  logic done_iflag,
  input  logic nmi_pulse,
  input  logic irq_pulse,
  input  logic halt_set,
  output logic nmi_pend,
  output logic os_pend,
  output logic jammed,
  output logic i_prev
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_pend <= 1'b0;
      os_pend  <= 1'b0;
      jammed   <= 1'b0;
      i_prev   <= 1'b1;
    end else begin
      // a new pulse wins over the clear of an accepted boundary
      nmi_pend <= nmi_pulse | (nmi_pend & ~accept);
      os_pend  <= irq_pulse | (os_pend & ~accept);
      jammed   <= jammed | halt_set;
      if (done) i_prev <= done_iflag;
    end
  end

endmodule

// File: rtl/isq_arbiter.sv
module isq_arbiter
  import isq_pkg::*;
#(
  parameter int IRQ_SRC = 4
) (
  input  logic               nmi_pend,
  input  logic               os_pend,
  input  logic               jammed,
  input  logic               i_prev,
  input  logic [IRQ_SRC-1:0] irq_level,
  output kind_e              kind_sel
);

  logic irq_any;

  generate
    if (IRQ_SRC > 0) begin : g_lvl
      assign irq_any = (|irq_level) | os_pend;
    end else begin : g_nolvl
      assign irq_any = os_pend;
    end
  endgenerate

  always_comb begin
    kind_sel = K_NONE;
    if (!jammed) begin
      if (nmi_pend)               kind_sel = K_NMI;
      else if (irq_any && !i_prev) kind_sel = K_IRQ;
    end
  end

endmodule

// File: rtl/isq_bus_mux.sv
module isq_bus_mux
  import isq_pkg::*;
#(
  parameter int             DW         = 8,
  parameter logic [DW-1:0]  STACK_PAGE = 8'h01,
  localparam int            AW         = 2 * DW
) (
  input  phase_e          phase,
  input  kind_e           kind_q,
  input  logic [AW-1:0]   pc_q,
  input  logic [DW-1:0]   st_q,
  input  logic [DW-1:0]   sp_q,
  output logic            bus_valid,
  output logic            bus_write,
  output logic [AW-1:0]   bus_addr,
  output logic [DW-1:0]   bus_wdata
);

  localparam logic [AW-1:0] ADDR_TOP = '1;
  localparam logic [AW-1:0] A_NMI    = ADDR_TOP - AW'(OFS_NMI);
  localparam logic [AW-1:0] A_RST    = ADDR_TOP - AW'(OFS_RST);
  localparam logic [AW-1:0] A_IRQ    = ADDR_TOP - AW'(OFS_IRQ);
  localparam logic [DW-1:0] U_MASK   = DW'(1) << FLG_U;

  logic [AW-1:0] vec_base;

  always_comb begin
    case (kind_q)
      K_NMI:   vec_base = A_NMI;
      K_IRQ:   vec_base = A_IRQ;
      default: vec_base = A_RST;
    endcase
  end

  always_comb begin
    bus_valid = 1'b0;
    bus_write = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    case (phase)
      PH_PSH_H: begin
        bus_valid = 1'b1;
        bus_write = 1'b1;
        bus_addr  = {STACK_PAGE, sp_q};
        bus_wdata = pc_q[AW-1:DW];
      end
      PH_PSH_L: begin
        bus_valid = 1'b1;
        bus_write = 1'b1;
        bus_addr  = {STACK_PAGE, sp_q};
        bus_wdata = pc_q[DW-1:0];
      end
      PH_PSH_P: begin
        bus_valid = 1'b1;
        bus_write = 1'b1;
        bus_addr  = {STACK_PAGE, sp_q};
        bus_wdata = st_q | U_MASK;
      end
      PH_VEC_L: begin
        bus_valid = 1'b1;
        bus_addr  = vec_base;
      end
      PH_VEC_H: begin
        bus_valid = 1'b1;
        bus_addr  = vec_base + AW'(1);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/isq_fsm.sv
module isq_fsm
  import isq_pkg::*;
#(
  parameter int            DW      = 8,
  parameter logic [DW-1:0] SP_INIT = 8'h00,
  localparam int           AW      = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  kind_e         kind_sel,
  input  logic [AW-1:0] cur_pc,
  input  logic [DW-1:0] cur_status,
  input  logic [DW-1:0] cur_sp,
  input  logic          bus_ready,
  input  logic [DW-1:0] bus_rdata,
  output phase_e        phase,
  output kind_e         kind_q,
  output logic [AW-1:0] pc_q,
  output logic [DW-1:0] st_q,
  output logic [DW-1:0] sp_q
);

  localparam logic [DW-1:0] B_MASK     = DW'(1) << FLG_B;
  localparam logic [DW-1:0] RST_STATUS = DW'(1) << FLG_I;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_BOOT;
      kind_q <= K_RESET;
      pc_q   <= '0;
      st_q   <= RST_STATUS;
      sp_q   <= SP_INIT;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (accept) begin
            pc_q   <= cur_pc;
            sp_q   <= cur_sp;
            kind_q <= kind_sel;
            if (kind_sel == K_NONE) begin
              st_q  <= cur_status;
              phase <= PH_FIN;
            end else begin
              st_q  <= cur_status & ~B_MASK;
              phase <= PH_PSH_H;
            end
          end
        end
        PH_BOOT: phase <= PH_VEC_L;
        PH_PSH_H: begin
          if (bus_ready) begin
            sp_q  <= sp_q - DW'(1);
            phase <= PH_PSH_L;
          end
        end
        PH_PSH_L: begin
          if (bus_ready) begin
            sp_q  <= sp_q - DW'(1);
            phase <= PH_PSH_P;
          end
        end
        PH_PSH_P: begin
          if (bus_ready) begin
            sp_q <= sp_q - DW'(1);
            if (kind_q == K_IRQ) st_q[FLG_I] <= 1'b1;
            phase <= PH_VEC_L;
          end
        end
        PH_VEC_L: begin
          if (bus_ready) begin
            pc_q[DW-1:0] <= bus_rdata;
            phase        <= PH_VEC_H;
          end
        end
        PH_VEC_H: begin
          if (bus_ready) begin
            pc_q[AW-1:DW] <= bus_rdata;
            phase         <= PH_FIN;
          end
        end
        PH_FIN:  phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq
  import isq_pkg::*;
#(
  parameter int            DW         = 8,
  parameter int            IRQ_SRC    = 4,
  parameter logic [DW-1:0] STACK_PAGE = 8'h01,
  parameter logic [DW-1:0] SP_INIT    = 8'h00,
  localparam int           AW         = 2 * DW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bnd_start,
  input  logic [AW-1:0]      cur_pc,
  input  logic [DW-1:0]      cur_status,
  input  logic [DW-1:0]      cur_sp,
  input  logic               nmi_pulse,
  input  logic [IRQ_SRC-1:0] irq_level,
  input  logic               irq_pulse,
  input  logic               halt_set,
  output logic               bus_valid,
  input  logic               bus_ready,
  output logic               bus_write,
  output logic [AW-1:0]      bus_addr,
  output logic [DW-1:0]      bus_wdata,
  input  logic [DW-1:0]      bus_rdata,
  output logic               seq_busy,
  output logic               seq_done,
  output logic [1:0]         seq_kind,
  output logic [AW-1:0]      next_pc,
  output logic [DW-1:0]      next_status,
  output logic [DW-1:0]      next_sp
);

  phase_e        phase;
  kind_e         kind_q;
  kind_e         kind_sel;
  logic [AW-1:0] pc_q;
  logic [DW-1:0] st_q;
  logic [DW-1:0] sp_q;
  logic          accept;
  logic          nmi_pend;
  logic          os_pend;
  logic          jammed;
  logic          i_prev;

  assign accept      = bnd_start && (phase == PH_IDLE);
  assign seq_busy    = (phase != PH_IDLE);
  assign seq_done    = (phase == PH_FIN);
  assign seq_kind    = kind_q;
  assign next_pc     = pc_q;
  assign next_status = st_q;
  assign next_sp     = sp_q;

  isq_req_latch u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .done       (seq_done),
    .done_iflag (st_q[FLG_I]),
    .nmi_pulse  (nmi_pulse),
    .irq_pulse  (irq_pulse),
    .halt_set   (halt_set),
    .nmi_pend   (nmi_pend),
    .os_pend    (os_pend),
    .jammed     (jammed),
    .i_prev     (i_prev)
  );

  isq_arbiter #(.IRQ_SRC(IRQ_SRC)) u_arb (
    .nmi_pend  (nmi_pend),
    .os_pend   (os_pend),
    .jammed    (jammed),
    .i_prev    (i_prev),
    .irq_level (irq_level),
    .kind_sel  (kind_sel)
  );

  isq_fsm #(.DW(DW), .SP_INIT(SP_INIT)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .kind_sel   (kind_sel),
    .cur_pc     (cur_pc),
    .cur_status (cur_status),
    .cur_sp     (cur_sp),
    .bus_ready  (bus_ready),
    .bus_rdata  (bus_rdata),
    .phase      (phase),
    .kind_q     (kind_q),
    .pc_q       (pc_q),
    .st_q       (st_q),
    .sp_q       (sp_q)
  );

  isq_bus_mux #(.DW(DW), .STACK_PAGE(STACK_PAGE)) u_mux (
    .phase     (phase),
    .kind_q    (kind_q),
    .pc_q      (pc_q),
    .st_q      (st_q),
    .sp_q      (sp_q),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata)
  );

endmodule

// File: rtl/intr_entry_seq_chk.sv
module intr_entry_seq_chk #(
  parameter int            DW         = 8,
  parameter logic [DW-1:0] STACK_PAGE = 8'h01,
  localparam int           AW         = 2 * DW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_valid,
  input logic          bus_ready,
  input logic          bus_write,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          seq_busy,
  input logic          seq_done,
  input logic [1:0]    seq_kind,
  input logic [DW-1:0] next_status
);

  localparam logic [AW-1:0] VEC_FLOOR = {AW{1'b1}} - AW'(5);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_write) && $stable(bus_addr) && $stable(bus_wdata)); // R11

  AST_PUSH_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_write |-> bus_addr[AW-1:DW] == STACK_PAGE); // R3

  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_write |-> bus_addr >= VEC_FLOOR); // R5

  AST_REQ_IN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> seq_busy && !seq_done); // R12

  AST_DONE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done && !seq_busy); // R12

  AST_IRQ_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done && seq_kind == 2'd3 |-> next_status[2]); // R7

  AST_BRK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done && seq_kind[1] |-> !next_status[4]); // R4

  AST_RST_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done && seq_kind == 2'd1 |-> next_status == DW'(4)); // R1

endmodule

bind intr_entry_seq intr_entry_seq_chk #(.DW(DW), .STACK_PAGE(STACK_PAGE)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_valid   (bus_valid),
  .bus_ready   (bus_ready),
  .bus_write   (bus_write),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .seq_busy    (seq_busy),
  .seq_done    (seq_done),
  .seq_kind    (seq_kind),
  .next_status (next_status)
);

// File: tb/intr_entry_seq_test.sv
`timescale 1ns/1ps
module intr_entry_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bnd_start = 1'b0;
  logic [15:0] cur_pc = '0;
  logic [7:0]  cur_status = '0;
  logic [7:0]  cur_sp = '0;
  logic        nmi_pulse = 1'b0;
  logic [3:0]  irq_level = '0;
  logic        irq_pulse = 1'b0;
  logic        halt_set = 1'b0;
  logic        bus_valid;
  logic        bus_ready = 1'b1;
  logic        bus_write;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic        seq_busy;
  logic        seq_done;
  logic [1:0]  seq_kind;
  logic [15:0] next_pc;
  logic [7:0]  next_status;
  logic [7:0]  next_sp;

  logic [15:0] v_nmi = 16'hC123;
  logic [15:0] v_rst = 16'h8000;
  logic [15:0] v_irq = 16'hE456;

  int  checks = 0;
  int  errors = 0;
  bit  ended = 0;
  bit  rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  intr_entry_seq uut (.*);

  // memory: vectors answered combinationally from the address
  always_comb begin
    case (bus_addr)
      16'hFFFA: bus_rdata = v_nmi[7:0];
      16'hFFFB: bus_rdata = v_nmi[15:8];
      16'hFFFC: bus_rdata = v_rst[7:0];
      16'hFFFD: bus_rdata = v_rst[15:8];
      16'hFFFE: bus_rdata = v_irq[7:0];
      16'hFFFF: bus_rdata = v_irq[15:8];
      default:  bus_rdata = 8'h00;
    endcase
  end

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    bus_ready = rdy_mode ? lfsr[0] : 1'b1;
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  bit          mq_wr[$];
  logic [15:0] mq_a[$];
  logic [7:0]  mq_d[$];
  string       mq_tag[$];
  bit          m_boot, m_busy, m_done, m_nmi, m_os, m_jam, m_iprev;
  logic [1:0]  m_kind;
  logic [15:0] m_pc;
  logic [7:0]  m_st, m_sp;
  string       m_tag;

  task automatic qop(input bit w, input logic [15:0] a, input logic [7:0] d, input string t);
    mq_wr.push_back(w); mq_a.push_back(a); mq_d.push_back(d); mq_tag.push_back(t);
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      mq_wr.delete(); mq_a.delete(); mq_d.delete(); mq_tag.delete();
      qop(0, 16'hFFFC, 8'h00, "R1");
      qop(0, 16'hFFFD, 8'h00, "R1");
      m_boot = 1; m_busy = 1; m_done = 0; m_kind = 2'd1;
      m_pc = v_rst; m_st = 8'h04; m_sp = 8'h00; m_tag = "R1";
      m_nmi = 0; m_os = 0; m_jam = 0; m_iprev = 1;
    end else begin
      bit acc;
      logic [1:0] k;
      acc = 0;
      chk("R12 busy", seq_busy, m_busy);
      chk("R11 valid", bus_valid, (!m_boot && mq_a.size() > 0));
      if (bus_valid && !m_boot && mq_a.size() > 0) begin
        chk({mq_tag[0], " dir"}, bus_write, mq_wr[0]);
        chk({mq_tag[0], " addr"}, bus_addr, mq_a[0]);
        if (mq_wr[0]) chk({mq_tag[0], " wdata"}, bus_wdata, mq_d[0]);
      end
      chk({m_tag, " done"}, seq_done, m_done);
      if (m_done && seq_done) begin
        chk({m_tag, " kind"}, seq_kind, m_kind);
        chk({m_tag, " pc"}, next_pc, m_pc);
        chk({m_tag, " status"}, next_status, m_st);
        chk({m_tag, " sp"}, next_sp, m_sp);
      end
      // predict the state after the coming edge
      if (m_boot) m_boot = 0;
      else if (m_done) begin
        m_done = 0; m_busy = 0; m_iprev = m_st[2];
      end else if (mq_a.size() > 0) begin
        if (bus_ready) begin
          void'(mq_wr.pop_front()); void'(mq_a.pop_front());
          void'(mq_d.pop_front()); void'(mq_tag.pop_front());
          if (mq_a.size() == 0) m_done = 1;
        end
      end else if (!m_busy && bnd_start) begin
        acc = 1;
        k = 2'd0;
        if (!m_jam) begin
          if (m_nmi) k = 2'd2;
          else if (((|irq_level) || m_os) && !m_iprev) k = 2'd3;
        end
        m_kind = k; m_busy = 1;
        if (k == 2'd0) begin
          m_pc = cur_pc; m_st = cur_status; m_sp = cur_sp; m_done = 1;
          m_tag = m_jam ? "R9" : "R10";
        end else begin
          qop(1, {8'h01, cur_sp}, cur_pc[15:8], "R3");
          qop(1, {8'h01, cur_sp - 8'd1}, cur_pc[7:0], "R3");
          qop(1, {8'h01, cur_sp - 8'd2}, (cur_status & 8'hEF) | 8'h20, "R4");
          qop(0, (k == 2'd2) ? 16'hFFFA : 16'hFFFE, 8'h00, "R5");
          qop(0, (k == 2'd2) ? 16'hFFFB : 16'hFFFF, 8'h00, "R5");
          m_pc = (k == 2'd2) ? v_nmi : v_irq;
          m_st = cur_status & 8'hEF;
          if (k == 2'd3) m_st[2] = 1'b1;
          m_sp = cur_sp - 8'd3;
          m_tag = (k == 2'd2) ? "R6" : "R7";
        end
      end
      if (acc) begin m_nmi = 0; m_os = 0; end
      if (nmi_pulse) m_nmi = 1;
      if (irq_pulse) m_os = 1;
      if (halt_set)  m_jam = 1;
    end
  end

  // ---------------- stimulus ----------------
  task automatic pulse(input bit n, input bit i, input bit h);
    @(posedge clk); #1;
    nmi_pulse = n; irq_pulse = i; halt_set = h;
    @(posedge clk); #1;
    nmi_pulse = 0; irq_pulse = 0; halt_set = 0;
  endtask

  task automatic boundary(input logic [15:0] pc, input logic [7:0] st, input logic [7:0] sp,
                          input logic [1:0] ek, input string tag, input bit timed,
                          input bit poke, input bit nmi_also);
    int cnt;
    @(posedge clk); #1;
    cur_pc = pc; cur_status = st; cur_sp = sp;
    bnd_start = 1; nmi_pulse = nmi_also;
    cnt = 0;
    do begin
      @(posedge clk); #1;
      bnd_start = poke && (cnt == 1);
      nmi_pulse = 0;
      cnt++;
      @(negedge clk);
    end while (!seq_done && cnt < 200);
    bnd_start = 0;
    chk({tag, " boundary kind"}, seq_kind, ek);
    if (timed) chk("R2 cycles to done", cnt, (ek == 2'd0) ? 1 : 6);
  endtask

  task automatic do_reset;
    int cnt;
    @(posedge clk); #1 rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!seq_done && cnt < 200);
    chk("R1 reset kind", seq_kind, 2'd1);
    chk("R1 reset pc", next_pc, v_rst);
    chk("R1 reset cycles", cnt, 4);
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    do_reset();
    boundary(16'h0200, 8'h00, 8'hFF, 2'd0, "R10", 1, 0, 0);
    pulse(1, 0, 0);
    boundary(16'h1234, 8'h00, 8'hFD, 2'd2, "R6", 1, 0, 0);
    irq_level = 4'b0010;
    boundary(16'h2000, 8'h04, 8'hFA, 2'd3, "R7 prior flag clear", 1, 0, 0);
    boundary(16'h2100, 8'h00, 8'hF7, 2'd0, "R7 prior flag set", 1, 0, 0);
    boundary(16'h2200, 8'h30, 8'hF7, 2'd3, "R4", 1, 0, 0);
    irq_level = 4'b0000;
    boundary(16'h2300, 8'h00, 8'hF4, 2'd0, "R10", 1, 0, 0);
    pulse(1, 1, 0);
    boundary(16'h3000, 8'h00, 8'hF4, 2'd2, "R6 priority", 1, 0, 0);
    boundary(16'h3100, 8'h00, 8'hF1, 2'd0, "R8 both cleared", 1, 0, 0);
    pulse(0, 1, 0);
    boundary(16'h3200, 8'h00, 8'hF1, 2'd3, "R8 oneshot", 1, 0, 0);
    pulse(0, 1, 0);
    boundary(16'h3300, 8'h00, 8'hEE, 2'd0, "R8 masked oneshot", 1, 0, 0);
    boundary(16'h3400, 8'h00, 8'hEE, 2'd0, "R8 oneshot dropped", 1, 0, 0);
    boundary(16'h3500, 8'h00, 8'hEE, 2'd0, "R8 same-cycle pulse", 1, 0, 1);
    boundary(16'h3600, 8'h00, 8'h01, 2'd2, "R8 pulse kept, R3 wrap", 1, 0, 0);
    pulse(1, 0, 0);
    boundary(16'h3700, 8'h00, 8'h80, 2'd2, "R12 poke", 1, 1, 0);
    boundary(16'h3800, 8'h00, 8'h80, 2'd0, "R12 no rerun", 1, 0, 0);
    rdy_mode = 1;
    v_nmi = 16'h9ABC;
    pulse(1, 0, 0);
    boundary(16'h4000, 8'h80, 8'h40, 2'd2, "R11 nmi stalls", 0, 0, 0);
    irq_level = 4'b1000;
    boundary(16'h4100, 8'h00, 8'h40, 2'd3, "R11 irq stalls", 0, 0, 0);
    irq_level = 4'b0000;
    rdy_mode = 0;
    @(posedge clk); #1;
    pulse(1, 0, 1);
    boundary(16'h5000, 8'h00, 8'h30, 2'd0, "R9 halted nmi", 1, 0, 0);
    irq_level = 4'b0001;
    boundary(16'h5100, 8'h00, 8'h30, 2'd0, "R9 halted irq", 1, 0, 0);
    irq_level = 4'b0000;
    v_rst = 16'hA55A;
    do_reset();
    pulse(1, 0, 0);
    boundary(16'h6000, 8'h00, 8'hFF, 2'd2, "R9 cleared by reset", 1, 0, 0);
    repeat (4) @(posedge clk);
    finish_run();
  end

endmodule